// File: doc/BRIEF.md
# Configurable Interrupt Line Conditioner

This block takes one raw interrupt request from a device and turns it into a clean pending flag for an interrupt controller. The raw line is asynchronous to the block's clock, so it first crosses a two-stage synchronizer. Every later decision uses the synchronized copy.

The active sense is programmable. It is either high or low, which also means either rising or falling. The line can be conditioned in one of three ways. In level mode the flag simply tracks the line. In edge mode a single transition into the active state is latched and held. In hybrid mode an edge is accepted only if the line then remains active for a programmable number of cycles, which rejects short glitches.

In the two latching modes the flag stays set until a clear strobe arrives from software or from the downstream controller. A request that arrives in the same cycle as a clear is not lost.

Top module: `irq_line_cond`

## Requirements
- R1: While reset is asserted, and after it is released with the line idle and polarity high, `pending` is 0.
- R2: In level mode (`mode` = 2'b00), `pending` equals the active state of `irq_raw` as it was three rising clock edges earlier: two synchronizer stages and one output register.
- R3: With `pol_low` = 0 the active state is high and the active edge is rising. With `pol_low` = 1 the active state is low and the active edge is falling.
- R4: In level mode `clr` has no effect: `pending` stays 1 while the line is held active, even with `clr` high.
- R5: In edge mode (`mode` = 2'b01, and 2'b11 behaves the same), a pulse of at least one clock sets `pending` three edges after the line goes active. The flag stays set after the line returns to inactive.
- R6: In edge and hybrid modes, `clr` sampled high at a rising edge clears `pending` at that edge when no new event arrives at the same edge.
- R7: When a new accepted event and `clr` land on the same rising edge, `pending` ends up 1.
- R8: In hybrid mode (`mode` = 2'b10) with `persist_len` = N > 0, an active pulse lasting W clocks sets `pending` if and only if W >= N+1. When it is accepted, `pending` rises 3+N edges after the line goes active.
- R9: In hybrid mode with `persist_len` = 0, behaviour is identical to edge mode: a single-cycle pulse is latched three edges later.
- R10: The persistence counter is 8 bits wide. With N = 255, a pulse of 255 clocks is rejected and a pulse of 256 clocks is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| irq_raw | input | 1 | Raw, asynchronous interrupt request line |
| pol_low | input | 1 | 0: active high / rising; 1: active low / falling |
| mode | input | 2 | 00 level, 01 edge, 10 hybrid, 11 edge |
| persist_len | input | 8 | Hybrid persistence length N in cycles |
| clr | input | 1 | Service strobe that clears a latched request |
| pending | output | 1 | Conditioned request flag to the interrupt controller |

## Verification
Changes in level mode and accepted edges show up on `pending` three rising edges after the line changes. A hybrid acceptance shows up N edges later than that. A clear takes effect at the very edge that samples it.

The bench drives inputs on falling edges and counts rising edges before each sample. Its latency checks look one edge before the due edge, expecting 0, and at the due edge, expecting 1. The accept/reject sweeps wait well past the longest window before they read the flag. The collision case aligns `clr` exactly with the edge at which the second request is due.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL    = 2'b00,
    MODE_EDGE     = 2'b01,
    MODE_HYBRID   = 2'b10,
    MODE_EDGE_ALT = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_bit_sync.sv
module irq_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_rest
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_event_det.sv
module irq_event_det
  import irq_cond_pkg::*;
#(
  parameter int PERSIST_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_i,
  input  logic [1:0]           mode_i,
  input  logic [PERSIST_W-1:0] persist_i,
  output logic                 event_o
);
  localparam int CW = PERSIST_W + 1;

  logic                 prev_q;
  logic                 armed_q, armed_d;
  logic [PERSIST_W-1:0] cnt_q, cnt_d;
  logic                 cnt_en;
  logic                 edge_hit, confirm, hybrid;
  logic [CW-1:0]        cnt_inc;

  assign hybrid   = (mode_i == MODE_HYBRID);
  assign edge_hit = act_i & ~prev_q;
  assign cnt_inc  = {1'b0, cnt_q} + CW'(1);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    confirm = 1'b0;
    if (hybrid) begin
      if (armed_q) begin
        if (!act_i) begin
          armed_d = 1'b0;
          cnt_d   = '0;
        end else if (cnt_inc >= {1'b0, persist_i}) begin
          confirm = 1'b1;
          armed_d = 1'b0;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_inc[PERSIST_W-1:0];
        end
      end else if (edge_hit) begin
        if (persist_i == '0) confirm = 1'b1;
        else                 armed_d = 1'b1;
        cnt_d = '0;
      end
    end else begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end
  end

  assign cnt_en  = (cnt_d != cnt_q);
  assign event_o = hybrid ? confirm : edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q  <= act_i;
      armed_q <= armed_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q != {PERSIST_W{1'b1}}));

  assert_persist_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o && hybrid && persist_i != '0) |-> (act_i && prev_q));
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic act_i,
  input  logic event_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    if (level_i) pend_d = act_i;
    else         pend_d = event_i | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && pend_q && !clr_i) |=> (pend_q || level_i));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && event_i) |=> (pend_q || level_i));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && clr_i && !event_i) |=> (!pend_q || level_i));
endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond
  import irq_cond_pkg::*;
#(
  parameter int PERSIST_W   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 irq_raw,
  input  logic                 pol_low,
  input  logic [1:0]           mode,
  input  logic [PERSIST_W-1:0] persist_len,
  input  logic                 clr,
  output logic                 pending
);
  logic rst_s;
  logic line_s;
  logic act;
  logic ev;
  logic is_level;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_s)
  );

  irq_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .d_i   (irq_raw),
    .q_o   (line_s)
  );

  assign act      = line_s ^ pol_low;
  assign is_level = (mode == MODE_LEVEL);

  irq_event_det #(.PERSIST_W(PERSIST_W)) u_det (
    .clk       (clk),
    .rst_n     (rst_s),
    .act_i     (act),
    .mode_i    (mode),
    .persist_i (persist_len),
    .event_o   (ev)
  );

  irq_pend_reg u_pend (
    .clk     (clk),
    .rst_n   (rst_s),
    .level_i (is_level),
    .act_i   (act),
    .event_i (ev),
    .clr_i   (clr),
    .pend_o  (pending)
  );

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_level_track_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (SYNC_STAGES == 2 && warm_q == 2'd3 && $past(mode) == MODE_LEVEL)
      |-> (pending == ($past(irq_raw, 3) ^ $past(pol_low))));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_s |-> !pending);
endmodule

// File: tb/irq_line_cond_test.sv
`timescale 1ns/1ps
module irq_line_cond_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_raw;
  logic       pol_low;
  logic [1:0] mode;
  logic [7:0] persist_len;
  logic       clr;
  logic       pending;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_line_cond uut (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .pol_low(pol_low),
    .mode(mode), .persist_len(persist_len), .clr(clr), .pending(pending)
  );

  task automatic check(input string req, input logic act_v, input logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: pending=%0b expected=%0b (pol=%0b mode=%0d N=%0d)",
               req, act_v, exp_v, pol_low, mode, persist_len);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic prep(input logic p, input logic [1:0] m, input logic [7:0] n);
    pol_low     = p;
    mode        = m;
    persist_len = n;
    irq_raw     = p;
    ticks(8);
    clr = 1'b1;
    ticks(1);
    clr = 1'b0;
    ticks(1);
    if (m != 2'b00) check("R6 clear before test", pending, 1'b0);
  endtask

  task automatic pulse(input logic p, input int w);
    irq_raw = ~p;
    ticks(w);
    irq_raw = p;
  endtask

  task automatic latency(input logic p, input logic [1:0] m, input logic [7:0] n,
                         input string req);
    int due;
    prep(p, m, n);
    due = (m == 2'b10) ? 3 + int'(n) : 3;
    irq_raw = ~p;
    ticks(due - 1);
    check({req, " one edge early"}, pending, 1'b0);
    ticks(1);
    check({req, " due edge"}, pending, 1'b1);
    irq_raw = p;
    ticks(2);
    if (m != 2'b00) check("R5 sticky after release", pending, 1'b1);
    ticks(4);
  endtask

  initial begin
    rst_n = 1'b0; irq_raw = 1'b0; pol_low = 1'b0; mode = 2'b01;
    persist_len = 8'd0; clr = 1'b0;
    ticks(4);
    check("R1 in reset", pending, 1'b0);
    rst_n = 1'b1;
    ticks(6);
    check("R1 after release", pending, 1'b0);

    // level mode: latency, polarity, clear ignored
    for (int p = 0; p < 2; p++) begin
      latency(logic'(p), 2'b00, 8'd0, "R2 R3 level rise");
      irq_raw = ~logic'(p);
      ticks(4);
      clr = 1'b1;
      ticks(3);
      check("R4 level ignores clr", pending, 1'b1);
      clr = 1'b0;
      irq_raw = logic'(p);
      ticks(2);
      check("R2 level fall early", pending, 1'b1);
      ticks(1);
      check("R2 level fall due", pending, 1'b0);
    end

    // edge modes 01 and 11, polarity both, widths 1..3
    for (int p = 0; p < 2; p++) begin
      for (int mi = 0; mi < 2; mi++) begin
        logic [1:0] m;
        m = (mi == 0) ? 2'b01 : 2'b11;
        latency(logic'(p), m, 8'd0, "R3 R5 edge latency");
        for (int w = 1; w <= 3; w++) begin
          prep(logic'(p), m, 8'd0);
          pulse(logic'(p), w);
          ticks(8);
          check("R5 edge pulse latched", pending, 1'b1);
        end
      end
    end

    // hybrid sweep
    for (int p = 0; p < 2; p++) begin
      for (int ni = 0; ni < 5; ni++) begin
        int n;
        n = (ni == 4) ? 5 : ni;
        latency(logic'(p), 2'b10, 8'(n), (n == 0) ? "R9 hybrid N=0 latency" : "R8 hybrid latency");
        for (int w = 1; w <= n + 2; w++) begin
          prep(logic'(p), 2'b10, 8'(n));
          pulse(logic'(p), w);
          ticks(n + 8);
          check((n == 0) ? "R9 hybrid N=0 pulse" : "R8 hybrid accept rule",
                pending, logic'(w >= n + 1));
        end
      end
    end

    // full-width persistence
    prep(1'b0, 2'b10, 8'd255);
    pulse(1'b0, 255);
    ticks(264);
    check("R10 N=255 W=255 rejected", pending, 1'b0);
    prep(1'b0, 2'b10, 8'd255);
    pulse(1'b0, 256);
    ticks(264);
    check("R10 N=255 W=256 accepted", pending, 1'b1);

    // clear and new event on the same edge
    prep(1'b0, 2'b01, 8'd0);
    pulse(1'b0, 1);
    ticks(5);
    check("R5 first edge latched", pending, 1'b1);
    irq_raw = 1'b1;
    ticks(1);
    irq_raw = 1'b0;
    ticks(1);
    clr = 1'b1;
    ticks(1);
    clr = 1'b0;
    check("R7 event wins over clr", pending, 1'b1);
    ticks(3);
    clr = 1'b1;
    ticks(1);
    clr = 1'b0;
    check("R6 clr clears", pending, 1'b0);
    ticks(4);
    check("R6 stays cleared", pending, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule